// File: doc/BRIEF.md
# Sectored Decoded-Instruction Cache

This block holds instructions that the decode stage has already decoded. It sits next to the fetch stage of a single-issue, in-order pipeline. When a fetch address hits, the decoded word comes straight from this store, and the pipeline skips both the instruction-cache read and the decoder for that instruction. Each cycle it serves one lookup. On the other side, the decode stage offers each decoded instruction as a fill. The offer carries a flag that says whether the decoded form fits the narrow slot width. Only instructions that fit are stored.

The storage is sectored. A sector groups several neighbouring lines under a single tag, and every instruction slot in the sector has its own valid bit. So slots fill one by one, in any order. When a fill arrives under a foreign tag, the sector is taken over and all of its slots are emptied before the new one is written. With the default parameters the store is 512 bytes of data: 32-bit decoded words, 4 slots per line, 4 lines per sector, and 8 sectors.

Both the lookup port and the fill port are valid-only streams with no ready signal. The cache accepts a lookup and a fill in every cycle, so it never applies back-pressure. A lookup always gets its response exactly one cycle later. The source must keep `lk_valid` high only in cycles that carry a request.

Top module: `sectored_dec_cache`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rsp_valid` is 0. Every lookup after reset, before any fill, misses.
- R2: A lookup accepted in cycle N gives `rsp_valid`=1 in cycle N+1, together with `rsp_hit` and `rsp_word`. Without a lookup, `rsp_valid` is 0 in the next cycle.
- R3: A lookup hits only when two things are true: the addressed sector holds a valid tag equal to the lookup tag, and the addressed slot's valid bit is set. On a hit, `rsp_word` is the word written by the most recent accepted fill to that slot. On a miss, `rsp_word` is 0.
- R4: A fill with `fl_cacheable`=0 changes nothing. A slot that was valid keeps its old word, and a slot that was empty stays empty.
- R5: A fill whose tag matches the sector's valid tag writes only its own slot. Every other slot in the sector keeps its state.
- R6: A fill whose tag misses the sector, or that arrives when the sector's tag is not valid, replaces the sector. The new tag is written, all slot valid bits in that sector are cleared, and then only the written slot is set valid.
- R7: A lookup whose tag matches the sector's tag but whose slot was never filled is reported as a miss.
- R8: `flush`=1 clears every tag-valid bit and every slot-valid bit in one cycle. A fill offered in the same cycle is dropped.
- R9: A lookup and a fill to the same slot in the same cycle return the contents from before the fill. A flush in the same cycle as a lookup also leaves that lookup's response as it was before the flush.
- R10: The byte address maps as follows. Bits [1:0] are ignored. Bits [5:2] select the slot within the sector: line = bits [5:4], word in line = bits [3:2]. Bits [8:6] select the sector. Bits [31:9] are the tag. A fill never changes a sector other than the one it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every tag and slot this cycle |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | 32 | Lookup byte address |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | That lookup hit |
| rsp_word | output | 32 | Decoded word on a hit, 0 otherwise |
| fl_valid | input | 1 | Fill offer present |
| fl_addr | input | 32 | Fill byte address |
| fl_word | input | 32 | Decoded word to store |
| fl_cacheable | input | 1 | Decoded form fits a slot; 0 means do not store |

## Verification
The lookup path is tried in several ways. Lookups go to empty slots under a matching tag, which separates the per-slot valid check from the tag check. Lookups repeat at addresses that differ only in bits [1:0], which shows the byte offset is ignored. Lookups follow a fill under a second tag in the same sector, which shows whether a replacement really empties the neighbouring slots.

Fills are offered with the cacheable flag low on both valid and empty slots, to show they have no effect. A lookup and a fill hit the same slot in the same cycle, and a flush is combined with a fill, to pin down which happens first. A long random mix over two tags and two sectors is then compared every cycle against a behavioural model. That mix finds decode mistakes in the slot, sector and tag fields.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // Kind of update a fill offer causes in its sector.
  typedef enum logic [1:0] {
    FILL_NONE    = 2'd0,
    FILL_SLOT    = 2'd1,
    FILL_REPLACE = 2'd2
  } fill_kind_e;
endpackage

// File: rtl/sdc_tag_store.sv
module sdc_tag_store #(
  parameter int NUM_SECTORS = 8,
  parameter int TAG_W       = 23,
  localparam int SEC_IW     = $clog2(NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [SEC_IW-1:0] lk_sec,
  output logic [TAG_W-1:0]  lk_tag,
  output logic              lk_tvld,
  input  logic [SEC_IW-1:0] fl_sec,
  output logic [TAG_W-1:0]  fl_tag,
  output logic              fl_tvld,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag
);
  logic [TAG_W-1:0]       tag_q [NUM_SECTORS];
  logic [NUM_SECTORS-1:0] tvld_q;

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tvld_q[s] <= 1'b0;
        tag_q[s]  <= '0;
      end else if (flush) begin
        tvld_q[s] <= 1'b0;
      end else if (wr_en && fl_sec == SEC_IW'(s)) begin
        tvld_q[s] <= 1'b1;
        tag_q[s]  <= wr_tag;
      end
    end
  end

  assign lk_tag  = tag_q[lk_sec];
  assign lk_tvld = tvld_q[lk_sec];
  assign fl_tag  = tag_q[fl_sec];
  assign fl_tvld = tvld_q[fl_sec];

  assert_flush_drops_tags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tvld_q == '0));
  assert_replace_installs_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (tvld_q[$past(fl_sec)] && tag_q[$past(fl_sec)] == $past(wr_tag)));
endmodule

// File: rtl/sdc_slot_store.sv
module sdc_slot_store #(
  parameter int NUM_SECTORS = 8,
  parameter int SPS         = 16,
  parameter int SLOT_W      = 32,
  localparam int SEC_IW     = $clog2(NUM_SECTORS),
  localparam int SLOT_IW    = $clog2(SPS),
  localparam int TOTAL      = NUM_SECTORS * SPS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [SEC_IW-1:0]  rd_sec,
  input  logic [SLOT_IW-1:0] rd_slot,
  output logic               rd_vld,
  output logic [SLOT_W-1:0]  rd_word,
  input  logic               wr_en,
  input  logic               wr_clear,
  input  logic [SEC_IW-1:0]  wr_sec,
  input  logic [SLOT_IW-1:0] wr_slot,
  input  logic [SLOT_W-1:0]  wr_word
);
  logic [NUM_SECTORS-1:0][SPS-1:0] vld_q;
  logic [SLOT_W-1:0]               data_q [TOTAL];

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
    logic [SPS-1:0] sel;
    always_comb begin
      sel = '0;
      sel[wr_slot] = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        vld_q[s] <= '0;
      end else if (wr_en && wr_sec == SEC_IW'(s)) begin
        vld_q[s] <= (wr_clear ? '0 : vld_q[s]) | sel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) data_q[{wr_sec, wr_slot}] <= wr_word;
  end

  assign rd_vld  = vld_q[rd_sec][rd_slot];
  assign rd_word = data_q[{rd_sec, rd_slot}];

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
  assert_idle_keeps_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !flush) |=> $stable(vld_q));
  assert_replace_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_clear && !flush) |=> ($countones(vld_q[$past(wr_sec)]) == 1));
  assert_write_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> vld_q[$past(wr_sec)][$past(wr_slot)]);
endmodule

// File: rtl/sectored_dec_cache.sv
module sectored_dec_cache #(
  parameter int ADDR_W           = 32,
  parameter int SLOT_W           = 32,
  parameter int INSTR_BYTES      = 4,
  parameter int SLOTS_PER_LINE   = 4,
  parameter int LINES_PER_SECTOR = 4,
  parameter int CAPACITY_BYTES   = 512,
  localparam int SPS         = SLOTS_PER_LINE * LINES_PER_SECTOR,
  localparam int NUM_SECTORS = (CAPACITY_BYTES * 8 / SLOT_W) / SPS,
  localparam int OFS_W       = $clog2(INSTR_BYTES),
  localparam int SLOT_IW     = $clog2(SPS),
  localparam int SEC_IW      = $clog2(NUM_SECTORS),
  localparam int TAG_W       = ADDR_W - OFS_W - SLOT_IW - SEC_IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [SLOT_W-1:0] rsp_word,
  input  logic              fl_valid,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [SLOT_W-1:0] fl_word,
  input  logic              fl_cacheable
);
  import sdc_pkg::*;

  logic [SLOT_IW-1:0] lk_slot, fl_slot;
  logic [SEC_IW-1:0]  lk_sec, fl_sec;
  logic [TAG_W-1:0]   lk_tag, fl_tag;
  logic [TAG_W-1:0]   cur_lk_tag, cur_fl_tag;
  logic               cur_lk_tvld, cur_fl_tvld;
  logic               slot_vld;
  logic [SLOT_W-1:0]  slot_word;
  fill_kind_e         kind;
  logic               hit_c;

  assign lk_slot = lk_addr[OFS_W +: SLOT_IW];
  assign lk_sec  = lk_addr[OFS_W + SLOT_IW +: SEC_IW];
  assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
  assign fl_slot = fl_addr[OFS_W +: SLOT_IW];
  assign fl_sec  = fl_addr[OFS_W + SLOT_IW +: SEC_IW];
  assign fl_tag  = fl_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    if (!fl_valid || !fl_cacheable || flush)            kind = FILL_NONE;
    else if (cur_fl_tvld && cur_fl_tag == fl_tag)       kind = FILL_SLOT;
    else                                                kind = FILL_REPLACE;
  end

  sdc_tag_store #(.NUM_SECTORS(NUM_SECTORS), .TAG_W(TAG_W)) i_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_sec(lk_sec), .lk_tag(cur_lk_tag), .lk_tvld(cur_lk_tvld),
    .fl_sec(fl_sec), .fl_tag(cur_fl_tag), .fl_tvld(cur_fl_tvld),
    .wr_en(kind == FILL_REPLACE), .wr_tag(fl_tag)
  );

  sdc_slot_store #(.NUM_SECTORS(NUM_SECTORS), .SPS(SPS), .SLOT_W(SLOT_W)) i_slots (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd_sec(lk_sec), .rd_slot(lk_slot), .rd_vld(slot_vld), .rd_word(slot_word),
    .wr_en(kind != FILL_NONE), .wr_clear(kind == FILL_REPLACE),
    .wr_sec(fl_sec), .wr_slot(fl_slot), .wr_word(fl_word)
  );

  assign hit_c = lk_valid && cur_lk_tvld && (cur_lk_tag == lk_tag) && slot_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_word  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= hit_c;
      rsp_word  <= hit_c ? slot_word : '0;
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_hit_needs_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  assert_miss_word_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_word == '0));
endmodule

// File: tb/test_sectored_dec_cache.sv
module test_sectored_dec_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_word;
  logic        fl_valid = 1'b0;
  logic [31:0] fl_addr = '0;
  logic [31:0] fl_word = '0;
  logic        fl_cacheable = 1'b0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sectored_dec_cache i_sectored_dec_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_word(rsp_word),
    .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_word(fl_word),
    .fl_cacheable(fl_cacheable)
  );

  // Behavioural reference: slot=[5:2], sector=[8:6], tag=[31:9] (R10)
  logic [22:0] m_tag [8];
  bit          m_tv  [8];
  bit          m_sv  [128];
  logic [31:0] m_dat [128];

  function automatic int idx(input logic [31:0] a);
    return int'(a[8:6]) * 16 + int'(a[5:2]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_tv[i] = 0;
    for (int i = 0; i < 128; i++) m_sv[i] = 0;
  endtask

  // One clock: drive at negedge, model update, compare at next negedge.
  // want: -1 no directed expectation, 0 expect miss, 1 expect hit.
  task automatic step(input bit lkv, input logic [31:0] la,
                      input bit flv, input logic [31:0] fa, input logic [31:0] fw,
                      input bit fc, input bit fls, input int want, input string rq);
    bit e_hit;
    logic [31:0] e_word;
    int fs;
    lk_valid = lkv; lk_addr = la;
    fl_valid = flv; fl_addr = fa; fl_word = fw; fl_cacheable = fc;
    flush = fls;
    e_hit  = lkv && m_tv[la[8:6]] && (m_tag[la[8:6]] == la[31:9]) && m_sv[idx(la)];
    e_word = e_hit ? m_dat[idx(la)] : 32'h0;
    if (fls) model_reset();
    else if (flv && fc) begin
      fs = int'(fa[8:6]);
      if (!(m_tv[fs] && m_tag[fs] == fa[31:9])) begin
        m_tv[fs] = 1; m_tag[fs] = fa[31:9];
        for (int i = 0; i < 16; i++) m_sv[fs*16 + i] = 0;
      end
      m_sv[idx(fa)] = 1; m_dat[idx(fa)] = fw;
    end
    @(posedge clk);
    @(negedge clk);
    total++;
    if (rsp_valid !== lkv || (lkv && (rsp_hit !== e_hit || rsp_word !== e_word))) begin
      bad++;
      $display("FAIL %s: valid/hit/word = %0b/%0b/%h expected %0b/%0b/%h",
               rq, rsp_valid, rsp_hit, rsp_word, lkv, e_hit, e_word);
    end
    if (want >= 0) begin
      total++;
      if (rsp_hit !== want[0]) begin
        bad++;
        $display("FAIL %s: hit=%0b expected %0b", rq, rsp_hit, want[0]);
      end
    end
  endtask

  task automatic look(input logic [31:0] a, input int want, input string rq);
    step(1, a, 0, 0, 0, 0, 0, want, rq);
  endtask

  task automatic fill(input logic [31:0] a, input logic [31:0] w, input bit c, input string rq);
    step(0, 0, 1, a, w, c, 0, -1, rq);
  endtask

  localparam logic [31:0] T1 = 32'h0000_1000;  // tag 8
  localparam logic [31:0] T2 = 32'h0000_2000;  // tag 16

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++; $display("FAIL R1: rsp_valid=%0b expected 0 in reset", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++; $display("FAIL R1: rsp_valid=%0b expected 0 after reset", rsp_valid);
    end
    look(32'h0, 0, "R1");
    look(T1 | 32'h44, 0, "R1");

    // basic fill and hit; byte offset ignored
    fill(T1 | 32'h08, 32'hA5A5_0001, 1, "R3");
    look(T1 | 32'h08, 1, "R3");
    look(T1 | 32'h0B, 1, "R10");
    look(T2 | 32'h08, 0, "R3");
    // same tag, unfilled slot in that sector
    look(T1 | 32'h0C, 0, "R7");
    look(T1 | 32'h3C, 0, "R7");
    // neighbour in same sector, both hit
    fill(T1 | 32'h30, 32'hBEEF_0002, 1, "R5");
    look(T1 | 32'h30, 1, "R5");
    look(T1 | 32'h08, 1, "R5");
    // uncacheable: no change on valid and empty slots
    fill(T1 | 32'h08, 32'hDEAD_DEAD, 0, "R4");
    look(T1 | 32'h08, 1, "R4");
    fill(T1 | 32'h14, 32'hDEAD_DEAD, 0, "R4");
    look(T1 | 32'h14, 0, "R4");
    fill(T2 | 32'h14, 32'hDEAD_DEAD, 0, "R4");
    look(T1 | 32'h30, 1, "R4");
    // other sector independent
    fill(T1 | 32'h48, 32'h1111_0003, 1, "R10");
    look(T1 | 32'h48, 1, "R10");
    look(T1 | 32'h08, 1, "R10");
    // replacement under a different tag
    fill(T2 | 32'h20, 32'h2222_0004, 1, "R6");
    look(T2 | 32'h20, 1, "R6");
    look(T1 | 32'h08, 0, "R6");
    look(T2 | 32'h08, 0, "R6");
    look(T1 | 32'h48, 1, "R6");
    // same-cycle lookup and fill to one slot
    step(1, T2 | 32'h20, 1, T2 | 32'h20, 32'h3333_0005, 1, 0, 1, "R9");
    look(T2 | 32'h20, 1, "R9");
    step(1, T2 | 32'h24, 1, T2 | 32'h24, 32'h4444_0006, 1, 0, 0, "R9");
    look(T2 | 32'h24, 1, "R9");
    // flush: lookup in same cycle sees old, fill dropped
    step(1, T2 | 32'h24, 1, T1 | 32'h50, 32'h5555_0007, 1, 1, 1, "R8");
    look(T2 | 32'h24, 0, "R8");
    look(T1 | 32'h48, 0, "R8");
    look(T1 | 32'h50, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, -1, "R2");

    // random mix over two tags, two sectors
    for (int n = 0; n < 600; n++) begin
      logic [31:0] la, fa;
      la = (($urandom % 2) ? T1 : T2) | (($urandom % 2) << 6) | (($urandom % 16) << 2) | ($urandom % 4);
      fa = (($urandom % 2) ? T1 : T2) | (($urandom % 2) << 6) | (($urandom % 16) << 2);
      step($urandom % 4 != 0, la, $urandom % 2, fa, $urandom,
           $urandom % 4 != 0, $urandom % 64 == 0, -1, "R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule